// File: doc/BRIEF.md
# Fixed-Frequency Chopping Current Regulator

This block runs the switching of one H-bridge coil at a fixed chopping rate. A period counter, clocked by the system clock, sets the chop period from a two-bit rate code. Each period has three parts: a forced-charge window at its start, a middle part and a fast-decay tail. A comparator flag shows when the coil current is at or above its reference. The block uses this flag to pick one of two behaviours for each period.

If the current was seen below the reference at least once inside the forced-charge window, the bridge keeps charging until the flag rises. It then enters slow decay, and fast decay takes over for the last quarter of the period. If the current never dropped below the reference during the window, the bridge goes straight to fast decay for the rest of the period. A sign input selects the coil polarity. A zero magnitude holds the bridge in slow decay. A disable input switches all four gates off, reports the high-impedance state and restarts the period counter.

Gate outputs are registered. Any change between two different non-zero gate patterns passes through one clock with all gates off. This is the dead time.

Top module: `chop_regulator`

## Requirements
- R1: After reset all four gates are off and `bridge_hiz` is 1. The rate code is 00, which gives a period of 240 clocks with the default 96 MHz system clock.
- R2: Each period starts with the counter at zero. The bridge charges for the whole forced-charge window, which is the first P/8 clocks of a P-clock period.
- R3: If `above_ref` was low in any cycle of the window, the bridge keeps charging after the window until `above_ref` is high. From then until the tail it stays in slow decay (pattern 0101).
- R4: In the case of R3, fast decay covers the tail, from count P-P/4 to the end of the period.
- R5: If `above_ref` was high in every cycle of the window, fast decay runs from the end of the window to the end of the period.
- R6: The rate codes give these periods at 96 MHz: 00 gives 400 kHz (240 clocks), 01 gives 200 kHz (480), 10 gives 600 kHz (160) and 11 gives 300 kHz (320).
- R7: A code presented with `rate_wr` high is used from the next clock. If the counter is already past the new period length, the counter wraps at once.
- R8: The gate vector is {hi_a, lo_a, hi_b, lo_b}. For sign 0, charge is 1001 and fast decay is 0110. For sign 1 the two patterns swap. Slow decay is 0101 for both signs.
- R9: Gate outputs follow the selected pattern one clock later. Between two different non-zero patterns there is exactly one all-off clock.
- R10: When the magnitude is zero the bridge is in slow decay, or all-off during dead time.
- R11: With `coil_off` high, the next clock shows all gates off and `bridge_hiz` high. After release, a new period starts from count zero.
- R12: The high side and low side of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coil_off | input | 1 | Disable: gates off, counter restarted |
| rate_code | input | 2 | Chopping rate select code |
| rate_wr | input | 1 | Applies `rate_code` on this clock |
| above_ref | input | 1 | Comparator flag: coil current at or above reference |
| coil_sign | input | 1 | Coil polarity |
| coil_mag | input | MAG_W | Current magnitude; zero forces slow decay |
| gate_hi_a | output | 1 | High-side gate, leg A |
| gate_lo_a | output | 1 | Low-side gate, leg A |
| gate_hi_b | output | 1 | High-side gate, leg B |
| gate_lo_b | output | 1 | Low-side gate, leg B |
| bridge_hiz | output | 1 | Bridge in high-impedance state |

## Verification
Three comparator patterns exercise the decision between the two period behaviours:
- A flag that stays high through the window must produce fast decay for the rest of the period.
- A flag that drops inside the window and recovers later must produce charge, then slow decay, then the fast tail.
- A flag that never recovers must produce charge right up to the tail.

Random flag runs with persistence, random sign flips, zero magnitudes, rate rewrites in mid-period and short disable pulses test the dead-time rule and the counter wrap against a cycle model built in the bench. Each directed period measurement shows whether the counter limit for each rate code is correct.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

  typedef enum logic [1:0] {
    MD_CHARGE = 2'd0,
    MD_SLOW   = 2'd1,
    MD_FAST   = 2'd2
  } drive_mode_t;

  // Gate vector bit positions: {hi_a, lo_a, hi_b, lo_b}
  localparam int unsigned G_HI_A = 3;
  localparam int unsigned G_LO_A = 2;
  localparam int unsigned G_HI_B = 1;
  localparam int unsigned G_LO_B = 0;

  localparam logic [3:0] PAT_OFF  = 4'b0000;
  localparam logic [3:0] PAT_DIAG = 4'b1001;  // hi_a + lo_b
  localparam logic [3:0] PAT_RDIA = 4'b0110;  // hi_b + lo_a
  localparam logic [3:0] PAT_SLOW = 4'b0101;  // both low sides

  localparam int unsigned RATE_CODES = 4;

  function automatic int unsigned rate_hz(input logic [1:0] code);
    case (code)
      2'b00:   rate_hz = 400_000;
      2'b01:   rate_hz = 200_000;
      2'b10:   rate_hz = 600_000;
      default: rate_hz = 300_000;
    endcase
  endfunction

endpackage

// File: rtl/chop_timebase.sv
`timescale 1ns/1ps
module chop_timebase #(
  parameter int unsigned SYS_HZ = 96_000_000,
  parameter int unsigned CW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coil_off,
  input  logic [1:0]    rate_code,
  input  logic          rate_wr,
  output logic [CW-1:0] cnt,
  output logic          at_start,
  output logic          in_window,
  output logic          in_tail
);
  import chop_pkg::*;

  logic [1:0]    act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_m1  [RATE_CODES];
  logic [CW-1:0] win_end [RATE_CODES];
  logic [CW-1:0] tail_at [RATE_CODES];

  for (genvar g = 0; g < RATE_CODES; g++) begin : g_rate
    localparam int unsigned PER = SYS_HZ / rate_hz(2'(g));
    assign lim_m1[g]  = CW'(PER - 1);
    assign win_end[g] = CW'(PER / 8);
    assign tail_at[g] = CW'(PER - PER / 4);
  end

  always_comb begin
    act_d = act_q;
    if (rate_wr) act_d = rate_code;
  end

  always_comb begin
    if (coil_off)                   cnt_d = '0;
    else if (cnt_q >= lim_m1[act_q]) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 2'b00;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt       = cnt_q;
  assign at_start  = (cnt_q == '0);
  assign in_window = (cnt_q < win_end[act_q]);
  assign in_tail   = (cnt_q >= tail_at[act_q]);

endmodule

// File: rtl/chop_decider.sv
`timescale 1ns/1ps
module chop_decider (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  coil_off,
  input  logic                  at_start,
  input  logic                  in_window,
  input  logic                  in_tail,
  input  logic                  above_ref,
  input  logic                  mag_zero,
  output chop_pkg::drive_mode_t mode
);
  import chop_pkg::*;

  logic seen_q, seen_d;     // current below reference inside window
  logic reach_q, reach_d;   // reference reached after window

  always_comb begin
    if (coil_off) begin
      seen_d  = 1'b0;
      reach_d = 1'b0;
    end else begin
      seen_d  = (at_start ? 1'b0 : seen_q)  | (in_window & ~above_ref);
      reach_d = (at_start ? 1'b0 : reach_q) | (~in_window & above_ref);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      reach_q <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      reach_q <= reach_d;
    end
  end

  always_comb begin
    if (mag_zero)                    mode = MD_SLOW;
    else if (in_window)              mode = MD_CHARGE;
    else if (!seen_q)                mode = MD_FAST;
    else if (in_tail)                mode = MD_FAST;
    else if (reach_q || above_ref)   mode = MD_SLOW;
    else                             mode = MD_CHARGE;
  end

endmodule

// File: rtl/bridge_gater.sv
`timescale 1ns/1ps
module bridge_gater (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  coil_off,
  input  chop_pkg::drive_mode_t mode,
  input  logic                  polarity,
  output logic [3:0]            gates,
  output logic                  hiz
);
  import chop_pkg::*;

  logic [3:0] pat;
  logic [3:0] gates_q, gates_d;
  logic       hiz_q;

  always_comb begin
    case (mode)
      MD_CHARGE: pat = polarity ? PAT_RDIA : PAT_DIAG;
      MD_FAST:   pat = polarity ? PAT_DIAG : PAT_RDIA;
      MD_SLOW:   pat = PAT_SLOW;
      default:   pat = PAT_OFF;
    endcase
  end

  always_comb begin
    if (coil_off)                             gates_d = PAT_OFF;
    else if (gates_q != PAT_OFF && pat != gates_q) gates_d = PAT_OFF;
    else                                      gates_d = pat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q <= PAT_OFF;
      hiz_q   <= 1'b1;
    end else begin
      gates_q <= gates_d;
      hiz_q   <= coil_off;
    end
  end

  assign gates = gates_q;
  assign hiz   = hiz_q;

endmodule

// File: rtl/chop_regulator.sv
`timescale 1ns/1ps
module chop_regulator #(
  parameter int unsigned SYS_HZ = 96_000_000,
  parameter int unsigned MAG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coil_off,
  input  logic [1:0]       rate_code,
  input  logic             rate_wr,
  input  logic             above_ref,
  input  logic             coil_sign,
  input  logic [MAG_W-1:0] coil_mag,
  output logic             gate_hi_a,
  output logic             gate_lo_a,
  output logic             gate_hi_b,
  output logic             gate_lo_b,
  output logic             bridge_hiz
);
  import chop_pkg::*;

  localparam int unsigned PER_MAX = SYS_HZ / 200_000;
  localparam int unsigned CW      = $clog2(PER_MAX + 1);

  logic [1:0]    rs_q;
  logic          rst_n_i;
  logic [CW-1:0] cnt;
  logic          at_start, in_window, in_tail;
  drive_mode_t   mode;
  logic [3:0]    gates;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  chop_timebase #(.SYS_HZ(SYS_HZ), .CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n_i), .coil_off(coil_off),
    .rate_code(rate_code), .rate_wr(rate_wr),
    .cnt(cnt), .at_start(at_start), .in_window(in_window), .in_tail(in_tail)
  );

  chop_decider u_dec (
    .clk(clk), .rst_n(rst_n_i), .coil_off(coil_off),
    .at_start(at_start), .in_window(in_window), .in_tail(in_tail),
    .above_ref(above_ref), .mag_zero(coil_mag == '0), .mode(mode)
  );

  bridge_gater u_gate (
    .clk(clk), .rst_n(rst_n_i), .coil_off(coil_off),
    .mode(mode), .polarity(coil_sign), .gates(gates), .hiz(bridge_hiz)
  );

  assign gate_hi_a = gates[G_HI_A];
  assign gate_lo_a = gates[G_LO_A];
  assign gate_hi_b = gates[G_HI_B];
  assign gate_lo_b = gates[G_LO_B];

endmodule

// File: rtl/chop_regulator_chk.sv
`timescale 1ns/1ps
module chop_regulator_chk #(
  parameter int unsigned MAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coil_off,
  input logic [MAG_W-1:0] coil_mag,
  input logic             gate_hi_a,
  input logic             gate_lo_a,
  input logic             gate_hi_b,
  input logic             gate_lo_b,
  input logic             bridge_hiz
);
  logic [3:0] g;
  assign g = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};

  p_leg_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_a && gate_lo_a) && !(gate_hi_b && gate_lo_b));

  p_dead_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (g != 4'b0000 && $past(g) != 4'b0000) |-> (g == $past(g)));

  p_off_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    coil_off |=> (g == 4'b0000 && bridge_hiz));

  p_hiz_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_hiz |-> (g == 4'b0000));

  p_zero_slow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_mag == '0 && !coil_off) |=> (g == 4'b0000 || g == 4'b0101));

endmodule

bind chop_regulator chop_regulator_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .coil_off(coil_off), .coil_mag(coil_mag),
  .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
  .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b),
  .bridge_hiz(bridge_hiz)
);

// File: tb/chop_regulator_test.sv
`timescale 1ns/1ps
module chop_regulator_test;
  localparam int unsigned SYS_HZ = 96_000_000;
  localparam int unsigned MAG_W  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic coil_off, rate_wr, above_ref, coil_sign;
  logic [1:0] rate_code;
  logic [MAG_W-1:0] coil_mag;
  logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b, bridge_hiz;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chop_regulator #(.SYS_HZ(SYS_HZ), .MAG_W(MAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .coil_off(coil_off),
    .rate_code(rate_code), .rate_wr(rate_wr), .above_ref(above_ref),
    .coil_sign(coil_sign), .coil_mag(coil_mag),
    .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
    .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b), .bridge_hiz(bridge_hiz)
  );

  logic [3:0] gv;
  assign gv = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};

  function automatic int unsigned period_of(input logic [1:0] c);
    case (c)
      2'b00:   period_of = SYS_HZ / 400_000;
      2'b01:   period_of = SYS_HZ / 200_000;
      2'b10:   period_of = SYS_HZ / 600_000;
      default: period_of = SYS_HZ / 300_000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements
  logic [1:0]  m_rs, m_act;
  int unsigned m_cnt;
  logic        m_seen, m_reach, m_hiz;
  logic [3:0]  m_gates;
  string       m_tag;
  int unsigned mp, mw, mt;
  logic        minw, mtail, mst;
  logic [3:0]  mpat;
  int          mmode;  // 0 charge 1 slow 2 fast
  string       mreason;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00; m_act <= 2'b00; m_cnt <= 0; m_seen <= 1'b0;
      m_reach <= 1'b0; m_gates <= 4'b0000; m_hiz <= 1'b1; m_tag <= "R1";
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin
        mp = period_of(m_act); mw = mp / 8; mt = mp - mp / 4;
        minw = (m_cnt < mw); mtail = (m_cnt >= mt); mst = (m_cnt == 0);
        if (rate_wr) m_act <= rate_code;
        if (coil_off) begin
          m_cnt <= 0; m_seen <= 1'b0; m_reach <= 1'b0;
        end else begin
          m_cnt   <= (m_cnt >= mp - 1) ? 0 : m_cnt + 1;
          m_seen  <= (mst ? 1'b0 : m_seen)  | (minw & ~above_ref);
          m_reach <= (mst ? 1'b0 : m_reach) | (~minw & above_ref);
        end
        if (coil_mag == '0)             begin mmode = 1; mreason = "R10"; end
        else if (minw)                  begin mmode = 0; mreason = "R2"; end
        else if (!m_seen)               begin mmode = 2; mreason = "R5"; end
        else if (mtail)                 begin mmode = 2; mreason = "R4"; end
        else if (m_reach || above_ref)  begin mmode = 1; mreason = "R3"; end
        else                            begin mmode = 0; mreason = "R3"; end
        case (mmode)
          0:       mpat = coil_sign ? 4'b0110 : 4'b1001;
          2:       mpat = coil_sign ? 4'b1001 : 4'b0110;
          default: mpat = 4'b0101;
        endcase
        if (coil_off) begin
          m_gates <= 4'b0000; m_tag <= "R11";
        end else if (m_gates != 4'b0000 && mpat != m_gates) begin
          m_gates <= 4'b0000; m_tag <= "R9";
        end else begin
          m_gates <= mpat; m_tag <= mreason;
        end
        m_hiz <= coil_off;
      end
    end
  end

  // Every-cycle comparison against the model, plus leg exclusivity (R12)
  always @(negedge clk) begin
    if (!finished) begin
      chk(m_tag, {gv, bridge_hiz}, {m_gates, m_hiz});
      chk("R12", {3'b000, (gate_hi_a & gate_lo_a), (gate_hi_b & gate_lo_b)}, 5'b00000);
    end
  end

  task automatic wait_rise_a();
    logic prev;
    prev = gate_hi_a;
    forever begin
      @(negedge clk);
      if (gate_hi_a && !prev) break;
      prev = gate_hi_a;
    end
  endtask

  task automatic wait_rise_b();
    logic prev;
    prev = gate_hi_b;
    forever begin
      @(negedge clk);
      if (gate_hi_b && !prev) break;
      prev = gate_hi_b;
    end
  endtask

  task automatic write_rate(input logic [1:0] c);
    rate_code = c; rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic measure(input logic [1:0] c);
    int unsigned n;
    logic prev;
    write_rate(c);
    wait_rise_a();
    wait_rise_a();
    n = 0; prev = gate_hi_a;
    forever begin
      @(negedge clk); n++;
      if (gate_hi_a && !prev) break;
      prev = gate_hi_a;
    end
    chk("R6", 5'(n >> 4), 5'(period_of(c) >> 4));
    chk("R6", 5'(n & 15), 5'(period_of(c) & 15));
  endtask

  initial begin
    int unsigned k;
    logic prev;
    rst_n = 1'b0; coil_off = 1'b0; rate_code = 2'b00; rate_wr = 1'b0;
    above_ref = 1'b1; coil_sign = 1'b0; coil_mag = 8'h80;
    repeat (4) @(negedge clk);
    chk("R1", {gv, bridge_hiz}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {gv, bridge_hiz}, 5'b00001);

    // R1 default rate and R6 all codes
    measure(2'b00);
    measure(2'b01);
    measure(2'b10);
    measure(2'b11);
    measure(2'b00);

    // R3 / R4: below in window, recover mid-period
    wait_rise_a();
    above_ref = 1'b0;
    repeat (40) @(negedge clk);
    chk("R3", {gv, 1'b0}, {4'b1001, 1'b0});
    above_ref = 1'b1;
    repeat (60) @(negedge clk);
    chk("R3", {gv, 1'b0}, {4'b0101, 1'b0});
    repeat (100) @(negedge clk);
    chk("R4", {gv, 1'b0}, {4'b0110, 1'b0});

    // R2 / R5: never below in window
    wait_rise_a();
    repeat (10) @(negedge clk);
    chk("R2", {gv, 1'b0}, {4'b1001, 1'b0});
    repeat (90) @(negedge clk);
    chk("R5", {gv, 1'b0}, {4'b0110, 1'b0});

    // R4 with a flag that never recovers: charge up to the tail
    wait_rise_a();
    above_ref = 1'b0;
    repeat (150) @(negedge clk);
    chk("R4", {gv, 1'b0}, {4'b1001, 1'b0});
    repeat (50) @(negedge clk);
    chk("R4", {gv, 1'b0}, {4'b0110, 1'b0});
    above_ref = 1'b1;

    // R8: reversed polarity swaps the diagonals
    coil_sign = 1'b1;
    wait_rise_b();
    wait_rise_b();
    repeat (10) @(negedge clk);
    chk("R8", {gv, 1'b0}, {4'b0110, 1'b0});
    repeat (90) @(negedge clk);
    chk("R8", {gv, 1'b0}, {4'b1001, 1'b0});
    coil_sign = 1'b0;

    // R10: zero magnitude
    coil_mag = '0;
    repeat (3) @(negedge clk);
    chk("R10", {gv, 1'b0}, {4'b0101, 1'b0});
    repeat (200) @(negedge clk);
    chk("R10", {gv, 1'b0}, {4'b0101, 1'b0});
    coil_mag = 8'h80;

    // R11: disable and restart
    repeat (50) @(negedge clk);
    coil_off = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", {gv, bridge_hiz}, 5'b00001);
    coil_off = 1'b0;
    @(negedge clk);
    chk("R11", {gv, bridge_hiz}, {4'b1001, 1'b0});

    // R7: shorter rate written late in a long period wraps at once
    write_rate(2'b01);
    wait_rise_a();
    wait_rise_a();
    repeat (300) @(negedge clk);
    rate_code = 2'b10; rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
    k = 1; prev = gate_hi_a;
    while (!(gate_hi_a && !prev) && k < 200) begin
      prev = gate_hi_a;
      @(negedge clk); k++;
    end
    chk("R7", {4'b0000, (k <= 8)}, 5'b00001);
    write_rate(2'b00);

    // Random phase
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 30000; i++) begin
      int unsigned r;
      @(negedge clk);
      r = $urandom;
      if (r[4:0] == 5'd0) above_ref = ~above_ref;
      if ($urandom % 600 == 0) coil_mag = ($urandom % 3 == 0) ? '0 : MAG_W'($urandom % 255 + 1);
      if ($urandom % 700 == 0) coil_sign = ~coil_sign;
      if ($urandom % 900 == 0) begin rate_code = 2'($urandom); rate_wr = 1'b1; end
      else rate_wr = 1'b0;
      if (coil_off) begin if ($urandom % 20 == 0) coil_off = 1'b0; end
      else if ($urandom % 3000 == 0) coil_off = 1'b1;
    end
    @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 200_000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule